// File: doc/BRIEF.md
# Match Report Priority Encoder

The block gathers the match vectors of several parallel keyword-matching modules. Each module holds one bit per keyword and drives its vector every cycle. The block reduces all of them to a single report per cycle, so the chip needs only a narrow output instead of every module's vector. When at least one module shows a set bit, the block names one winning module by its binary index and forwards that module's whole vector unchanged. Software downstream can then separate several keywords that matched inside the same module.

Priority is fixed, and the lowest module index wins. Pattern sets are meant to be loaded so that the modules with the longest patterns sit at the lowest indices. A shorter pattern that overlaps a longer one can then be recovered later from the reported vector.

The reduction runs in two register stages so that it can sustain one byte per cycle at about 200 MHz. The first stage picks a winner inside each group of modules. The second stage picks the first group that has a winner. The report therefore appears a fixed two cycles after the vectors are presented, and a new set of vectors is accepted every cycle.

Top module: `mrp_report_encoder`

## Requirements
- R1: The match-valid output in any cycle reflects the vectors presented exactly two rising clock edges earlier. It is 1 when any bit of any module's vector was set.
- R2: When no module's vector had a set bit, match-valid is 0 and both the index and the vector outputs are all zero.
- R3: When exactly one module m has a nonzero vector, the index output equals m in binary and the vector output equals that module's vector. Module m occupies input bits [m*VEC_W +: VEC_W].
- R4: When several modules have nonzero vectors, the module with the lowest index is reported.
- R5: Every set bit of the winning module's vector appears unchanged at the vector output, including the case where several bits are set.
- R6: A new set of vectors is accepted on every clock. Consecutive different inputs produce consecutive independent reports, each two cycles later.
- R7: While the synchronous active-high reset is asserted, match-valid, index and vector outputs are held at zero, whatever the inputs are.
- R8: Priority holds across group boundaries. A winner in a lower group beats any module of a higher group, and the last module (index NUM_MODS-1) is reported when it alone matches.
- R9: The vectors of losing modules never reach the vector output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmv_i | input | NUM_MODS*VEC_W | Match vectors of all modules; module m in bits [m*VEC_W +: VEC_W] |
| hit_o | output | 1 | Match-valid flag |
| mod_idx_o | output | IDX_W | Binary index of the winning module |
| vec_o | output | VEC_W | Full match vector of the winning module |

## Verification
Two functions can act in the same cycle. One is the choice of a winner among several matching modules, inside a group and across groups. The other is the pass-through of a multi-bit vector while other modules' vectors are also nonzero. Directed cases set different bit patterns in a lower and a higher module in the same cycle, and then in two modules that sit in different groups. The bench judges each report by its index and its exact vector against a reference model computed from the requirements. A streaming case changes the inputs on every clock, so that reports from neighbouring cycles would be exposed if they mixed in the pipeline.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

    // Default sizing: eight modules of sixteen keywords, grouped by four
    localparam int MRP_NUM_MODS   = 8;
    localparam int MRP_VEC_W      = 16;
    localparam int MRP_GROUP_SIZE = 4;

    // Index width that never collapses to zero bits
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mrp_group_pick.sv
module mrp_group_pick #(
    parameter int GROUP_SIZE = mrp_pkg::MRP_GROUP_SIZE,
    parameter int VEC_W      = mrp_pkg::MRP_VEC_W,
    parameter int LOC_W      = mrp_pkg::idx_bits(GROUP_SIZE)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [GROUP_SIZE*VEC_W-1:0] vecs_i,
    output logic                        hit_o,
    output logic [LOC_W-1:0]            loc_o,
    output logic [VEC_W-1:0]            vec_o
);

    typedef struct packed {
        logic             hit;
        logic [LOC_W-1:0] loc;
        logic [VEC_W-1:0] vec;
    } pick_t;

    pick_t pick_d, pick_q;

    // Scan downwards so the lowest matching index is written last and wins
    always_comb begin
        pick_d = '0;
        for (int i = GROUP_SIZE - 1; i >= 0; i--) begin
            if (|vecs_i[i*VEC_W +: VEC_W]) begin
                pick_d.hit = 1'b1;
                pick_d.loc = LOC_W'(i);
                pick_d.vec = vecs_i[i*VEC_W +: VEC_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pick_q <= '0;
        else     pick_q <= pick_d;
    end

    assign hit_o = pick_q.hit;
    assign loc_o = pick_q.loc;
    assign vec_o = pick_q.vec;

    // R2
    grp_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (vec_o == '0 && loc_o == '0));

endmodule

// File: rtl/mrp_group_merge.sv
module mrp_group_merge #(
    parameter int NUM_GROUPS = 2,
    parameter int GROUP_SIZE = mrp_pkg::MRP_GROUP_SIZE,
    parameter int VEC_W      = mrp_pkg::MRP_VEC_W,
    parameter int LOC_W      = mrp_pkg::idx_bits(GROUP_SIZE),
    parameter int IDX_W      = mrp_pkg::idx_bits(NUM_GROUPS*GROUP_SIZE)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_GROUPS-1:0]       grp_hit_i,
    input  logic [NUM_GROUPS*LOC_W-1:0] grp_loc_i,
    input  logic [NUM_GROUPS*VEC_W-1:0] grp_vec_i,
    output logic                        hit_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic [VEC_W-1:0]            vec_o
);

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [VEC_W-1:0] vec;
    } report_t;

    report_t rep_d, rep_q;

    // Lowest group with a hit wins; index = group base + local offset
    always_comb begin
        rep_d = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (grp_hit_i[g]) begin
                rep_d.hit = 1'b1;
                rep_d.idx = IDX_W'(g*GROUP_SIZE + int'(grp_loc_i[g*LOC_W +: LOC_W]));
                rep_d.vec = grp_vec_i[g*VEC_W +: VEC_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rep_q <= '0;
        else     rep_q <= rep_d;
    end

    assign hit_o = rep_q.hit;
    assign idx_o = rep_q.idx;
    assign vec_o = rep_q.vec;

    // R5
    merge_hit_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (vec_o != '0));

endmodule

// File: rtl/mrp_report_encoder.sv
module mrp_report_encoder #(
    parameter int NUM_MODS   = mrp_pkg::MRP_NUM_MODS,
    parameter int VEC_W      = mrp_pkg::MRP_VEC_W,
    parameter int GROUP_SIZE = mrp_pkg::MRP_GROUP_SIZE,
    parameter int IDX_W      = mrp_pkg::idx_bits(NUM_MODS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_MODS*VEC_W-1:0] fmv_i,
    output logic                      hit_o,
    output logic [IDX_W-1:0]          mod_idx_o,
    output logic [VEC_W-1:0]          vec_o
);

    localparam int NUM_GROUPS = NUM_MODS / GROUP_SIZE;
    localparam int LOC_W      = mrp_pkg::idx_bits(GROUP_SIZE);

    initial begin
        if (NUM_GROUPS * GROUP_SIZE != NUM_MODS)
            $error("NUM_MODS must be a multiple of GROUP_SIZE");
    end

    logic [NUM_GROUPS-1:0]       grp_hit;
    logic [NUM_GROUPS*LOC_W-1:0] grp_loc;
    logic [NUM_GROUPS*VEC_W-1:0] grp_vec;

    // Stage 1: one picker per group
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        mrp_group_pick #(
            .GROUP_SIZE (GROUP_SIZE),
            .VEC_W      (VEC_W),
            .LOC_W      (LOC_W)
        ) u_pick (
            .clk    (clk),
            .rst    (rst),
            .vecs_i (fmv_i[g*GROUP_SIZE*VEC_W +: GROUP_SIZE*VEC_W]),
            .hit_o  (grp_hit[g]),
            .loc_o  (grp_loc[g*LOC_W +: LOC_W]),
            .vec_o  (grp_vec[g*VEC_W +: VEC_W])
        );
    end

    // Stage 2: merge across groups
    mrp_group_merge #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_SIZE (GROUP_SIZE),
        .VEC_W      (VEC_W),
        .LOC_W      (LOC_W),
        .IDX_W      (IDX_W)
    ) u_merge (
        .clk       (clk),
        .rst       (rst),
        .grp_hit_i (grp_hit),
        .grp_loc_i (grp_loc),
        .grp_vec_i (grp_vec),
        .hit_o     (hit_o),
        .idx_o     (mod_idx_o),
        .vec_o     (vec_o)
    );

    // Input history and age counter used only by the checks below
    logic [NUM_MODS*VEC_W-1:0] fmv_d1, fmv_d2;
    logic [1:0]                age;
    logic                      lower_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmv_d1 <= '0;
            fmv_d2 <= '0;
            age    <= '0;
        end else begin
            fmv_d1 <= fmv_i;
            fmv_d2 <= fmv_d1;
            if (age != 2'd2) age <= age + 2'd1;
        end
    end

    always_comb begin
        lower_clear = 1'b1;
        for (int m = 0; m < NUM_MODS; m++) begin
            if (m < int'(mod_idx_o) && (|fmv_d2[m*VEC_W +: VEC_W]))
                lower_clear = 1'b0;
        end
    end

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (mod_idx_o == '0 && vec_o == '0));

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (hit_o == (|fmv_d2)));

    // R3
    vec_source_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && hit_o) |-> (vec_o == fmv_d2[int'(mod_idx_o)*VEC_W +: VEC_W]));

    // R4
    priority_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && hit_o) |-> lower_clear);

endmodule

// File: tb/mrp_report_encoder_test.sv
module mrp_report_encoder_test;

    localparam int N  = 8;
    localparam int K  = 16;
    localparam int GS = 4;
    localparam int IW = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N*K-1:0]    fmv = '0;
    logic              hit;
    logic [IW-1:0]     idx;
    logic [K-1:0]      vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mrp_report_encoder #(
        .NUM_MODS   (N),
        .VEC_W      (K),
        .GROUP_SIZE (GS),
        .IDX_W      (IW)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .fmv_i     (fmv),
        .hit_o     (hit),
        .mod_idx_o (idx),
        .vec_o     (vec)
    );

    // Reference model: first nonzero module wins
    task automatic model(input logic [N*K-1:0] f, output logic eh,
                         output logic [IW-1:0] ei, output logic [K-1:0] ev);
        eh = 1'b0; ei = '0; ev = '0;
        for (int m = 0; m < N; m++) begin
            if (!eh && f[m*K +: K] != '0) begin
                eh = 1'b1; ei = IW'(m); ev = f[m*K +: K];
            end
        end
    endtask

    task automatic check_report(input string req, input logic eh,
                                input logic [IW-1:0] ei, input logic [K-1:0] ev);
        checks++;
        if (hit !== eh || idx !== ei || vec !== ev) begin
            fails++;
            $display("FAIL %s: got hit=%0b idx=%0d vec=%h, expected hit=%0b idx=%0d vec=%h",
                     req, hit, idx, vec, eh, ei, ev);
        end
    endtask

    // Present a vector set, wait two edges, check against the model
    task automatic apply_and_check(input string req, input logic [N*K-1:0] f);
        logic eh; logic [IW-1:0] ei; logic [K-1:0] ev;
        @(negedge clk); fmv = f;
        @(negedge clk);
        @(negedge clk);
        model(f, eh, ei, ev);
        check_report(req, eh, ei, ev);
    endtask

    function automatic logic [N*K-1:0] put(input logic [N*K-1:0] f, input int m,
                                           input logic [K-1:0] v);
        logic [N*K-1:0] r = f;
        r[m*K +: K] = v;
        return r;
    endfunction

    task automatic t_reset;
        @(negedge clk); rst = 1'b1; fmv = '1;
        @(negedge clk); @(negedge clk);
        check_report("R7 reset holds zero", 1'b0, '0, '0);
        @(negedge clk); rst = 1'b0; fmv = '0;
    endtask

    task automatic t_idle;
        apply_and_check("R2 no match", '0);
    endtask

    task automatic t_single;
        for (int m = 0; m < N; m++)
            apply_and_check("R3 single module", put('0, m, K'(16'h0100 << (m % 8)) | K'(m + 1)));
        apply_and_check("R8 last module alone", put('0, N - 1, 16'h8000));
    endtask

    task automatic t_multibit;
        apply_and_check("R5 many bits", put('0, 5, 16'hA5C3));
        apply_and_check("R5 all bits", put('0, 1, 16'hFFFF));
    endtask

    task automatic t_priority;
        apply_and_check("R4 two in group", put(put('0, 1, 16'h0F00), 3, 16'h00F0));
        apply_and_check("R8 across groups", put(put('0, 3, 16'h0002), 4, 16'h1000));
        apply_and_check("R8 upper group only", put(put('0, 6, 16'h0040), 4, 16'h0003));
        apply_and_check("R9 loser hidden", put(put('0, 2, 16'h0001), 5, 16'hFFFF));
        apply_and_check("R4 all modules", '1);
    endtask

    task automatic t_stream;
        logic [N*K-1:0] hist [0:19];
        logic eh; logic [IW-1:0] ei; logic [K-1:0] ev;
        for (int i = 0; i < 20; i++) begin
            hist[i] = '0;
            for (int m = 0; m < N; m++)
                if (((i * 7 + m * 3) % 5) == 0)
                    hist[i][m*K +: K] = K'(i * 311 + m * 97 + 1);
        end
        for (int i = 0; i < 22; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                model(hist[i-2], eh, ei, ev);
                check_report("R6 stream", eh, ei, ev);
            end
            if (i < 20) fmv = hist[i];
            else        fmv = '0;
        end
        // R1: outputs return to idle two edges after the last nonzero set
        @(negedge clk); @(negedge clk);
        check_report("R1 drain to idle", 1'b0, '0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_idle;
        t_single;
        t_multibit;
        t_priority;
        t_stream;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule